// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Validation

This block turns one binary-coded decimal digit into the seven lines that drive a single numeric display. The segments are named a (top bar) through g (middle bar). A polarity select makes the block usable with both display types:
- common-cathode displays, where a lit segment is a 1;
- common-anode displays, where a lit segment is a 0.

An enable input blanks the display on demand. Codes above nine are not treated as free choices. They are detected, the display goes dark, and a flag reports the bad code to the surrounding logic.

The digit, enable and validity result are captured in one register stage on the rising clock edge. The polarity is applied after that register, so the polarity select takes effect on the outputs at once. The invalid flag describes the code that was captured. It is valid whether or not the display is enabled.

Top module: `seg7_bcd_decoder`

## Requirements
- R1: While reset is high at a rising edge, the captured state is cleared. After that edge the segments are dark in the selected polarity and the invalid flag is 0, whatever the digit input holds.
- R2: Enable high, polarity active-high, code 0 to 9: one edge after the code is sampled, the segment output is {a,b,c,d,e,f,g} on bits 6 down to 0. The expected values are:
  - 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011;
  - 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R3: Codes 10 to 15 never light a segment. The output is the dark pattern of the selected polarity.
- R4: The invalid flag is digit bit 3 AND (bit 2 OR bit 1). It is 1 exactly for codes 10 to 15 and appears one edge after the code is sampled.
- R5: With the polarity input at 1 (active-low), every segment bit is the complement of its active-high value, including the dark pattern (all ones).
- R6: When enable is low at the sampling edge, the segments are dark for the selected polarity, for every code.
- R7: The invalid flag follows the code even while enable is low.
- R8: The digit and enable inputs reach the outputs only at the next rising edge. The polarity select changes the segment outputs in the same cycle, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_i | input | 4 | BCD code, bit 3 most significant |
| enable_i | input | 1 | 1 = show the digit, 0 = blank |
| active_low_i | input | 1 | 0 = lit segment is 1, 1 = lit segment is 0 |
| seg_o | output | 7 | Segment lines, bit 6 = a down to bit 0 = g |
| invalid_o | output | 1 | Captured code is above nine |

## Verification
The only state in the block is one register holding the active-high pattern and the validity bit. A wrong value there is visible at the ports from the very next edge and stays visible until the next input change. A wrong glyph entry shows up as a bad pattern for exactly one code. A polarity fault shows up at once as a pattern that is not the complement of the active-high one. A validity fault shows up either as a lit display paired with a raised flag, or as a dark display with the flag low.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    parameter int DIGIT_W   = 4;
    parameter int SEG_COUNT = 7;
    parameter int MAX_DIGIT = 9;

    localparam int CODE_COUNT = 1 << DIGIT_W;

    typedef logic [DIGIT_W-1:0]   digit_t;
    typedef logic [SEG_COUNT-1:0] seg_t;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } polarity_e;

    typedef struct packed {
        seg_t lit;   // active-high glyph, zero when dark
        logic bad;   // code above MAX_DIGIT
    } seg_word_t;

    // Bits 6..0 map to segments a..g; 1 lights the segment.
    function automatic seg_t glyph_of(input digit_t d);
        seg_t g;
        case (d)
            4'd0:    g = 7'b1111110;
            4'd1:    g = 7'b0110000;
            4'd2:    g = 7'b1101101;
            4'd3:    g = 7'b1111001;
            4'd4:    g = 7'b0110011;
            4'd5:    g = 7'b1011011;
            4'd6:    g = 7'b1011111;
            4'd7:    g = 7'b1110000;
            4'd8:    g = 7'b1111111;
            4'd9:    g = 7'b1111011;
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/seg7_code_check.sv
module seg7_code_check
    import seg7_pkg::*;
(
    input  digit_t digit,
    output logic   bad
);
    // Codes above nine all have the top bit set plus one of the next two.
    assign bad = digit[DIGIT_W-1] & (digit[DIGIT_W-2] | digit[DIGIT_W-3]);

    always_comb begin
        p_range_r4: assert (bad == (int'(digit) > MAX_DIGIT))
            else $error("validity does not match code range");
    end
endmodule

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
    import seg7_pkg::*;
(
    input  digit_t digit,
    output seg_t   lit
);
    assign lit = glyph_of(digit);

    always_comb begin
        if (int'(digit) <= MAX_DIGIT) begin
            p_digit_lit_r2: assert ($countones(lit) >= 2)
                else $error("decimal digit produced a near-empty glyph");
        end else begin
            p_nondigit_dark_r3: assert (lit == '0)
                else $error("code above nine produced a glyph");
        end
    end
endmodule

// File: rtl/seg7_polarity.sv
module seg7_polarity
    import seg7_pkg::*;
(
    input  seg_t      lit,
    input  polarity_e pol,
    output seg_t      drive
);
    localparam logic INV_HIGH = 1'b0;
    localparam logic INV_LOW  = 1'b1;

    logic invert;
    assign invert = (pol == POL_LOW) ? INV_LOW : INV_HIGH;

    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
        assign drive[i] = lit[i] ^ invert;
    end

    always_comb begin
        p_dark_polarity_r5: assert ((lit != '0) || (drive == {SEG_COUNT{pol == POL_LOW}}))
            else $error("dark pattern wrong for polarity");
    end
endmodule

// File: rtl/seg7_bcd_decoder.sv
module seg7_bcd_decoder
    import seg7_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIGIT_W-1:0]   digit_i,
    input  logic                 enable_i,
    input  logic                 active_low_i,
    output logic [SEG_COUNT-1:0] seg_o,
    output logic                 invalid_o
);
    logic      code_bad;
    seg_t      glyph;
    seg_word_t nxt_word;
    seg_word_t cur_word;
    polarity_e pol;

    seg7_code_check u_check (
        .digit (digit_i),
        .bad   (code_bad)
    );

    seg7_glyph_rom u_rom (
        .digit (digit_i),
        .lit   (glyph)
    );

    always_comb begin
        nxt_word.bad = code_bad;
        nxt_word.lit = (enable_i && !code_bad) ? glyph : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word <= '{lit: '0, bad: 1'b0};
        end else begin
            cur_word <= nxt_word;
        end
    end

    assign pol = polarity_e'(active_low_i);

    seg7_polarity u_pol (
        .lit   (cur_word.lit),
        .pol   (pol),
        .drive (seg_o)
    );

    assign invalid_o = cur_word.bad;

    p_disabled_dark_r6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (seg_o == {SEG_COUNT{active_low_i}}))
        else $error("display lit while disabled");

    p_invalid_blank_r3: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> (seg_o == {SEG_COUNT{active_low_i}}))
        else $error("display lit on invalid code");

    p_flag_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(digit_i) > MAX_DIGIT) |=> invalid_o)
        else $error("flag missed an invalid code");

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (int'(digit_i) <= MAX_DIGIT) |=> !invalid_o)
        else $error("flag raised on a decimal digit");

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!invalid_o && (seg_o == {SEG_COUNT{active_low_i}})))
        else $error("state not cleared by reset");
endmodule

// File: tb/tb_seg7_bcd_decoder.sv
module tb_seg7_bcd_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] digit_i;
    logic       enable_i;
    logic       active_low_i;
    logic [6:0] seg_o;
    logic       invalid_o;

    int checks = 0;
    int bad    = 0;

    always #2.5 clk = ~clk;

    seg7_bcd_decoder dut (
        .clk          (clk),
        .rst          (rst),
        .digit_i      (digit_i),
        .enable_i     (enable_i),
        .active_low_i (active_low_i),
        .seg_o        (seg_o),
        .invalid_o    (invalid_o)
    );

    // Expected active-high glyphs for 0..9, bits 6..0 = a..g.
    localparam logic [6:0] REF_GLYPH [10] = '{
        7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001, 7'b0110011,
        7'b1011011, 7'b1011111, 7'b1110000, 7'b1111111, 7'b1111011
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] d, input logic en, input logic al);
        @(negedge clk);
        digit_i      = d;
        enable_i     = en;
        active_low_i = al;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; digit_i = 4'd12; enable_i = 1'b1; active_low_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state dark, flag low even with a bad code applied
        check("R1 high", {invalid_o, seg_o}, 8'b0_0000000);
        active_low_i = 1'b1;
        #1;
        check("R1 low", {invalid_o, seg_o}, 8'b0_1111111);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: every code, both polarities, enable high and low.
        for (int al = 0; al < 2; al++) begin
            for (int en = 0; en < 2; en++) begin
                for (int code = 0; code < 16; code++) begin
                    logic [6:0] hi;
                    logic       inv;
                    drive(4'(code), en[0], al[0]);
                    @(posedge clk);
                    #1;
                    inv = (code >= 10);
                    hi  = (en == 1 && code < 10) ? REF_GLYPH[code] : 7'b0;
                    if (al == 1) hi = ~hi;
                    // R2 digits, R3 blanking, R4/R7 flag, R5 polarity, R6 enable
                    if (code < 10 && en == 1 && al == 0)
                        check("R2", {invalid_o, seg_o}, {inv, hi});
                    else if (code >= 10 && en == 1)
                        check("R3/R4", {invalid_o, seg_o}, {inv, hi});
                    else if (en == 0)
                        check("R6/R7", {invalid_o, seg_o}, {inv, hi});
                    else
                        check("R5", {invalid_o, seg_o}, {inv, hi});
                end
            end
        end

        // R8: digit change waits for the edge; polarity does not.
        drive(4'd3, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        digit_i = 4'd8;
        #1;
        check("R8 hold", {1'b0, seg_o}, {1'b0, REF_GLYPH[3]});
        @(posedge clk);
        #1;
        check("R8 update", {1'b0, seg_o}, {1'b0, REF_GLYPH[8]});
        @(negedge clk);
        active_low_i = 1'b1;
        #1;
        check("R8 polarity now", {1'b0, seg_o}, {1'b0, ~REF_GLYPH[8]});

        // R4 boundary: 9 then 10
        drive(4'd9, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R4 nine", {invalid_o, seg_o}, {1'b0, REF_GLYPH[9]});
        drive(4'd10, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R4 ten", {invalid_o, seg_o}, 8'b1_0000000);

        // R1: reset mid-run clears a lit pattern
        drive(4'd8, 1'b1, 1'b0);
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid", {invalid_o, seg_o}, 8'b0_0000000);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule